// File: doc/BRIEF.md
# ASID-Tagged IOMMU Translation Cache

This block caches completed I/O page-walk results for a device-side IOMMU. Every entry is keyed by a 16-bit address-space identifier together with a 48-bit I/O virtual address. Before it is used as a key, the address is rounded down to the granule in force, which is either 4 KiB or 64 KiB. An entry stores the translated page base, an address mask and a write-permission flag. The cache is fully associative and its depth is a parameter.

A requester presents a lookup. One cycle later the block returns a registered response, and that response reflects the contents as they stood before any update made in the same cycle. Separately, a page walker installs results through a fill port. Software-originated maintenance arrives on an invalidation port as one of five command codes: two full-flush codes, flush by identifier, flush by identifier plus address, and flush by address for every identifier. Two running counters record the number of hits and the number of misses.

Top module: `xlat_cache_top`

## Requirements
- R1: After reset no entry is valid, `rspValid` is 0, and both `hitCount` and `missCount` are 0.
- R2: A lookup that is presented in cycle N produces `rspValid` in cycle N+1. The lookup is a hit only if a valid entry has the same identifier and the same aligned key. The key is the address with its low 12 bits cleared when `lkGran`=0, or with its low 16 bits cleared when `lkGran`=1.
- R3: On a granted hit, `rspAddr` equals the cached base plus the incoming address bits below the granule boundary, and `rspMask` returns the cached mask. On a miss, both `rspAddr` and `rspMask` are 0.
- R4: A write lookup (`lkWrite`=1) that hits an entry without write permission sets `rspPermFault`=1 and `rspGrant`=0, and `rspAddr` is 0. A read hit, or a write hit on a writable entry, is granted without a fault.
- R5: Each lookup adds one to exactly one of `hitCount` and `missCount`, according to its outcome.
- R6: A fill with `fillOk`=1 installs its key, aligned by `fillGran`. A fill with `fillOk`=0 leaves no valid entry. A fill whose key is already present overwrites that entry in place.
- R7: A fill of a new key that arrives while all DEPTH entries are valid first clears every entry and then installs the new one.
- R8: Command codes 0 and 1 (full flush) and code 4 (address flush for any identifier) clear every entry.
- R9: Command code 2 clears every entry whose identifier equals `invAsid`. Entries with other identifiers are left in place.
- R10: Command code 3 clears the entry of identifier `invAsid` keyed by `invAddr` with its low 12 bits cleared, and also the entry keyed by `invAddr` with its low 16 bits cleared.
- R11: When an invalidation and a fill arrive in the same cycle, the invalidation is applied before the fill. A lookup in that cycle sees the contents from before both.
- R12: Command codes 5, 6 and 7 have no effect on the contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkValid | input | 1 | Lookup request strobe |
| lkAsid | input | 16 | Lookup address-space identifier |
| lkAddr | input | 48 | Lookup I/O virtual address |
| lkWrite | input | 1 | 1 for a write access |
| lkGran | input | 1 | Granule: 0 selects 4 KiB, 1 selects 64 KiB |
| fillValid | input | 1 | Fill strobe |
| fillOk | input | 1 | Page walk succeeded |
| fillAsid | input | 16 | Fill identifier |
| fillAddr | input | 48 | Fill virtual address |
| fillGran | input | 1 | Fill granule |
| fillBase | input | 48 | Translated page base |
| fillMask | input | 48 | Address mask to return on a hit |
| fillPermW | input | 1 | Write permitted |
| invValid | input | 1 | Invalidation strobe |
| invCmd | input | 3 | Invalidation command code |
| invAsid | input | 16 | Invalidation identifier |
| invAddr | input | 48 | Invalidation address |
| rspValid | output | 1 | Response valid, one cycle after a lookup |
| rspHit | output | 1 | The lookup hit |
| rspGrant | output | 1 | Access granted |
| rspPermFault | output | 1 | Write to a read-only entry |
| rspAddr | output | 48 | Translated address |
| rspMask | output | 48 | Cached address mask |
| hitCount | output | 32 | Number of hits |
| missCount | output | 32 | Number of misses |

## Verification
A lookup, a fill and an invalidation can all fall in the same cycle. The bench provokes this by driving all three together, in one case with a full flush and in another with a flush by identifier that names the fill's own identifier. The lookup issued in that cycle must report the contents from before the update. Later lookups must show that the freshly filled key survived and that the old key is gone, which proves that the invalidation was applied first.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;
  parameter int SMALL_SHIFT = 12;
  parameter int LARGE_SHIFT = 16;

  typedef enum logic [2:0] {
    CMD_ALL_STAGE1   = 3'd0,
    CMD_ALL_NONSEC   = 3'd1,
    CMD_BY_ASID      = 3'd2,
    CMD_BY_ASID_ADDR = 3'd3,
    CMD_BY_ADDR_ANY  = 3'd4
  } inv_cmd_e;

  typedef struct packed {
    logic lookup;
    logic fill;
    logic invAll;
    logic invAsid;
    logic invVa;
  } xlat_strobe_t;
endpackage

// File: rtl/xlat_cache_ctrl.sv
module xlat_cache_ctrl
  import xlat_cache_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic             fillValid,
  input  logic             fillOk,
  input  logic             invValid,
  input  logic [2:0]       invCmd,
  input  logic             lkAnyHit,
  output xlat_strobe_t     strb,
  output logic [CNT_W-1:0] hitCount,
  output logic [CNT_W-1:0] missCount
);
  always_comb begin
    strb        = '0;
    strb.lookup = lkValid;
    // a failed walk never reaches the entry array
    strb.fill   = fillValid & fillOk;
    if (invValid) begin
      case (invCmd)
        CMD_ALL_STAGE1, CMD_ALL_NONSEC, CMD_BY_ADDR_ANY: strb.invAll  = 1'b1;
        CMD_BY_ASID:                                     strb.invAsid = 1'b1;
        CMD_BY_ASID_ADDR:                                strb.invVa   = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitCount  <= '0;
      missCount <= '0;
    end else if (strb.lookup) begin
      if (lkAnyHit) hitCount  <= hitCount + 1'b1;
      else          missCount <= missCount + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_cache_dp.sv
module xlat_cache_dp
  import xlat_cache_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ASID_W = 16,
  parameter int VA_W   = 48,
  parameter int PA_W   = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlat_strobe_t      strb,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [VA_W-1:0]   lkAddr,
  input  logic              lkWrite,
  input  logic              lkGran,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic [VA_W-1:0]   fillAddr,
  input  logic              fillGran,
  input  logic [PA_W-1:0]   fillBase,
  input  logic [VA_W-1:0]   fillMask,
  input  logic              fillPermW,
  input  logic [ASID_W-1:0] invAsid,
  input  logic [VA_W-1:0]   invAddr,
  output logic              lkAnyHit,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspGrant,
  output logic              rspPermFault,
  output logic [PA_W-1:0]   rspAddr,
  output logic [VA_W-1:0]   rspMask
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [VA_W-1:0] SMALL_OFF = {{(VA_W-SMALL_SHIFT){1'b0}}, {SMALL_SHIFT{1'b1}}};
  localparam logic [VA_W-1:0] LARGE_OFF = {{(VA_W-LARGE_SHIFT){1'b0}}, {LARGE_SHIFT{1'b1}}};

  logic [DEPTH-1:0]  validQ, validAfterInv, validNext;
  logic [ASID_W-1:0] asidQ [DEPTH];
  logic [VA_W-1:0]   tagQ  [DEPTH];
  logic [PA_W-1:0]   baseQ [DEPTH];
  logic [VA_W-1:0]   maskQ [DEPTH];
  logic [DEPTH-1:0]  permWQ;

  logic [VA_W-1:0] lkOff, lkTag, fillTag, invTagSmall, invTagLarge;
  logic [DEPTH-1:0] lkHitVec, fillHitVec, invKill;

  assign lkOff       = lkGran ? LARGE_OFF : SMALL_OFF;
  assign lkTag       = lkAddr & ~lkOff;
  assign fillTag     = fillAddr & ~(fillGran ? LARGE_OFF : SMALL_OFF);
  assign invTagSmall = invAddr & ~SMALL_OFF;
  assign invTagLarge = invAddr & ~LARGE_OFF;

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    logic asidLk, asidInv, tagInv;
    assign asidLk        = asidQ[g] == lkAsid;
    assign asidInv       = asidQ[g] == invAsid;
    assign tagInv        = (tagQ[g] == invTagSmall) || (tagQ[g] == invTagLarge);
    assign lkHitVec[g]   = validQ[g] && asidLk && (tagQ[g] == lkTag);
    assign invKill[g]    = strb.invAll ||
                           (asidInv && (strb.invAsid || (strb.invVa && tagInv)));
    assign validAfterInv[g] = validQ[g] && !invKill[g];
    assign fillHitVec[g] = validAfterInv[g] && (asidQ[g] == fillAsid) && (tagQ[g] == fillTag);
  end

  // hit select: keys are unique, so at most one entry matches
  logic [PA_W-1:0] selBase;
  logic [VA_W-1:0] selMask;
  logic            selPermW;
  always_comb begin
    selBase  = '0;
    selMask  = '0;
    selPermW = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lkHitVec[i]) begin
        selBase  = selBase | baseQ[i];
        selMask  = selMask | maskQ[i];
        selPermW = selPermW | permWQ[i];
      end
    end
  end
  assign lkAnyHit = |lkHitVec;

  // fill slot: same key first, else first free, else flush and slot 0
  logic [IDX_W-1:0] matchSlot, freeSlot, wrSlot;
  logic matchAny, freeAny, isFull;
  always_comb begin
    matchSlot = '0;
    freeSlot  = '0;
    matchAny  = 1'b0;
    freeAny   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (fillHitVec[i] && !matchAny) begin
        matchSlot = IDX_W'(i);
        matchAny  = 1'b1;
      end
      if (!validAfterInv[i] && !freeAny) begin
        freeSlot = IDX_W'(i);
        freeAny  = 1'b1;
      end
    end
  end
  assign isFull = &validAfterInv;

  always_comb begin
    validNext = validAfterInv;
    wrSlot    = matchAny ? matchSlot : (isFull ? '0 : freeSlot);
    if (strb.fill) begin
      if (!matchAny && isFull) validNext = '0;
      validNext[wrSlot] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= '0;
    else       validQ <= validNext;
  end

  always_ff @(posedge clk) begin
    if (strb.fill) begin
      asidQ[wrSlot]  <= fillAsid;
      tagQ[wrSlot]   <= fillTag;
      baseQ[wrSlot]  <= fillBase;
      maskQ[wrSlot]  <= fillMask;
      permWQ[wrSlot] <= fillPermW;
    end
  end

  logic fault, grant;
  assign fault = lkAnyHit && lkWrite && !selPermW;
  assign grant = lkAnyHit && !fault;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspHit       <= 1'b0;
      rspGrant     <= 1'b0;
      rspPermFault <= 1'b0;
      rspAddr      <= '0;
      rspMask      <= '0;
    end else begin
      rspValid <= strb.lookup;
      if (strb.lookup) begin
        rspHit       <= lkAnyHit;
        rspGrant     <= grant;
        rspPermFault <= fault;
        rspAddr      <= grant ? (selBase + PA_W'(lkAddr & lkOff)) : '0;
        rspMask      <= lkAnyHit ? selMask : '0;
      end
    end
  end
endmodule

// File: rtl/xlat_cache_top.sv
module xlat_cache_top
  import xlat_cache_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ASID_W = 16,
  parameter int VA_W   = 48,
  parameter int PA_W   = 48,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [VA_W-1:0]   lkAddr,
  input  logic              lkWrite,
  input  logic              lkGran,
  input  logic              fillValid,
  input  logic              fillOk,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic [VA_W-1:0]   fillAddr,
  input  logic              fillGran,
  input  logic [PA_W-1:0]   fillBase,
  input  logic [VA_W-1:0]   fillMask,
  input  logic              fillPermW,
  input  logic              invValid,
  input  logic [2:0]        invCmd,
  input  logic [ASID_W-1:0] invAsid,
  input  logic [VA_W-1:0]   invAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspGrant,
  output logic              rspPermFault,
  output logic [PA_W-1:0]   rspAddr,
  output logic [VA_W-1:0]   rspMask,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount
);
  xlat_strobe_t strb;
  logic lkAnyHit;

  xlat_cache_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .fillValid(fillValid),
    .fillOk(fillOk), .invValid(invValid), .invCmd(invCmd),
    .lkAnyHit(lkAnyHit), .strb(strb), .hitCount(hitCount), .missCount(missCount)
  );

  xlat_cache_dp #(.DEPTH(DEPTH), .ASID_W(ASID_W), .VA_W(VA_W), .PA_W(PA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .lkAsid(lkAsid), .lkAddr(lkAddr), .lkWrite(lkWrite), .lkGran(lkGran),
    .fillAsid(fillAsid), .fillAddr(fillAddr), .fillGran(fillGran),
    .fillBase(fillBase), .fillMask(fillMask), .fillPermW(fillPermW),
    .invAsid(invAsid), .invAddr(invAddr), .lkAnyHit(lkAnyHit),
    .rspValid(rspValid), .rspHit(rspHit), .rspGrant(rspGrant),
    .rspPermFault(rspPermFault), .rspAddr(rspAddr), .rspMask(rspMask)
  );
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int PA_W  = 48,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             lkValid,
  input logic             rspValid,
  input logic             rspHit,
  input logic             rspGrant,
  input logic             rspPermFault,
  input logic [PA_W-1:0]  rspAddr,
  input logic [CNT_W-1:0] hitCount,
  input logic [CNT_W-1:0] missCount
);
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid); // R2
  AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rspValid); // R2
  AST_MISS_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspAddr == '0)); // R3
  AST_FAULT_NO_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    rspPermFault |-> (rspHit && !rspGrant && rspAddr == '0)); // R4
  AST_GRANT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    rspGrant |-> (rspHit && !rspPermFault)); // R4
  AST_COUNT_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> (CNT_W'(hitCount + missCount) ==
                 CNT_W'($past(hitCount) + $past(missCount) + 1'b1))); // R5
  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> ($stable(hitCount) && $stable(missCount))); // R5
endmodule

bind xlat_cache_top xlat_cache_chk #(.PA_W(PA_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .rspValid(rspValid),
  .rspHit(rspHit), .rspGrant(rspGrant), .rspPermFault(rspPermFault),
  .rspAddr(rspAddr), .hitCount(hitCount), .missCount(missCount)
);

// File: tb/sim_xlat_cache_top.sv
module sim_xlat_cache_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 0, lkWrite = 0, lkGran = 0;
  logic [15:0] lkAsid = '0;
  logic [47:0] lkAddr = '0;
  logic        fillValid = 0, fillOk = 0, fillGran = 0, fillPermW = 0;
  logic [15:0] fillAsid = '0;
  logic [47:0] fillAddr = '0, fillBase = '0, fillMask = '0;
  logic        invValid = 0;
  logic [2:0]  invCmd = '0;
  logic [15:0] invAsid = '0;
  logic [47:0] invAddr = '0;
  logic        rspValid, rspHit, rspGrant, rspPermFault;
  logic [47:0] rspAddr, rspMask;
  logic [31:0] hitCount, missCount;

  int checks = 0;
  int fails = 0;
  int expHits = 0;
  int expMiss = 0;
  bit done = 0;

  typedef struct {
    logic        hit;
    logic        fault;
    logic        grant;
    logic [47:0] addr;
    logic [47:0] mask;
    string       req;
  } expT;
  expT q[$];

  always #10 clk = ~clk;

  xlat_cache_top #(.DEPTH(4)) u0 (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkAsid(lkAsid), .lkAddr(lkAddr),
    .lkWrite(lkWrite), .lkGran(lkGran), .fillValid(fillValid), .fillOk(fillOk),
    .fillAsid(fillAsid), .fillAddr(fillAddr), .fillGran(fillGran),
    .fillBase(fillBase), .fillMask(fillMask), .fillPermW(fillPermW),
    .invValid(invValid), .invCmd(invCmd), .invAsid(invAsid), .invAddr(invAddr),
    .rspValid(rspValid), .rspHit(rspHit), .rspGrant(rspGrant),
    .rspPermFault(rspPermFault), .rspAddr(rspAddr), .rspMask(rspMask),
    .hitCount(hitCount), .missCount(missCount)
  );

  task automatic tick();
    @(negedge clk);
    lkValid = 0; fillValid = 0; invValid = 0;
  endtask

  task automatic look(input logic [15:0] a, input logic [47:0] va, input logic wr,
                      input logic gr, input logic eh, input logic ef,
                      input logic [47:0] ea, input logic [47:0] em, input string req);
    expT e;
    lkValid = 1; lkAsid = a; lkAddr = va; lkWrite = wr; lkGran = gr;
    e.hit = eh; e.fault = ef; e.grant = eh && !ef; e.addr = ea; e.mask = em; e.req = req;
    q.push_back(e);
    if (eh) expHits++; else expMiss++;
  endtask

  task automatic fill(input logic [15:0] a, input logic [47:0] va, input logic gr,
                      input logic [47:0] base, input logic [47:0] msk,
                      input logic w, input logic ok);
    fillValid = 1; fillAsid = a; fillAddr = va; fillGran = gr;
    fillBase = base; fillMask = msk; fillPermW = w; fillOk = ok;
  endtask

  task automatic inv(input logic [2:0] c, input logic [15:0] a, input logic [47:0] va);
    invValid = 1; invCmd = c; invAsid = a; invAddr = va;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (q.size() == 0) begin
        chk("R2 unexpected response", 64'd1, 64'd0);
      end else begin
        expT e;
        e = q.pop_front();
        chk(e.req, {rspHit, rspPermFault, rspGrant, 13'd0, rspAddr},
                   {e.hit, e.fault, e.grant, 13'd0, e.addr});
        if (e.hit) chk({e.req, " mask"}, {16'd0, rspMask}, {16'd0, e.mask});
        else       chk({e.req, " mask"}, {16'd0, rspMask}, 64'd0);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rspValid", {63'd0, rspValid}, 64'd0);
    chk("R1 hitCount", {32'd0, hitCount}, 64'd0);
    chk("R1 missCount", {32'd0, missCount}, 64'd0);
    look(16'd1, 48'h1234, 0, 0, 0, 0, 48'h0, 48'h0, "R1 empty miss"); tick();

    // R2 R3 basic fill and hit
    fill(16'd1, 48'h1000_5000, 0, 48'hA000_0000, 48'hFFF, 1, 1); tick();
    look(16'd1, 48'h1000_5ABC, 0, 0, 1, 0, 48'hA000_0ABC, 48'hFFF, "R3 4K hit offset"); tick();
    look(16'd2, 48'h1000_5ABC, 0, 0, 0, 0, 48'h0, 48'h0, "R2 other asid miss"); tick();
    look(16'd1, 48'h1000_5ABC, 1, 0, 1, 0, 48'hA000_0ABC, 48'hFFF, "R4 writable write grant"); tick();

    // R4 read-only 64K entry
    fill(16'd1, 48'h2_0000, 1, 48'hB000_0000, 48'hFFFF, 0, 1); tick();
    look(16'd1, 48'h2_3456, 0, 1, 1, 0, 48'hB000_3456, 48'hFFFF, "R3 64K hit offset"); tick();
    look(16'd1, 48'h2_3456, 1, 1, 1, 1, 48'h0, 48'hFFFF, "R4 write fault"); tick();
    look(16'd1, 48'h2_3456, 0, 0, 0, 0, 48'h0, 48'h0, "R2 granule key differs"); tick();

    // R6 failed walk, overwrite
    fill(16'd3, 48'h7000, 0, 48'h7000_0000, 48'hFFF, 1, 0); tick();
    look(16'd3, 48'h7000, 0, 0, 0, 0, 48'h0, 48'h0, "R6 failed walk no entry"); tick();
    fill(16'd1, 48'h1000_5000, 0, 48'hC000_0000, 48'hFFF, 1, 1); tick();
    look(16'd1, 48'h1000_5DEF, 0, 0, 1, 0, 48'hC000_0DEF, 48'hFFF, "R6 overwrite"); tick();

    // R9 flush by ASID
    fill(16'd2, 48'h9000, 0, 48'hD000_0000, 48'hFFF, 1, 1); tick();
    inv(3'd2, 16'd1, 48'h0); tick();
    look(16'd1, 48'h1000_5000, 0, 0, 0, 0, 48'h0, 48'h0, "R9 asid cleared"); tick();
    look(16'd2, 48'h9010, 0, 0, 1, 0, 48'hD000_0010, 48'hFFF, "R9 other asid kept"); tick();

    // R10 flush by ASID and address, both alignments
    fill(16'd2, 48'h3_0000, 1, 48'hE000_0000, 48'hFFFF, 1, 1); tick();
    fill(16'd2, 48'h3_1000, 0, 48'hF000_0000, 48'hFFF, 1, 1); tick();
    inv(3'd3, 16'd2, 48'h3_1234); tick();
    look(16'd2, 48'h3_1234, 0, 0, 0, 0, 48'h0, 48'h0, "R10 4K key cleared"); tick();
    look(16'd2, 48'h3_1234, 0, 1, 0, 0, 48'h0, 48'h0, "R10 64K key cleared"); tick();
    look(16'd2, 48'h9000, 0, 0, 1, 0, 48'hD000_0000, 48'hFFF, "R10 other key kept"); tick();

    // R12 unused codes
    inv(3'd5, 16'd2, 48'h9000); tick();
    inv(3'd6, 16'd2, 48'h9000); tick();
    inv(3'd7, 16'd2, 48'h9000); tick();
    look(16'd2, 48'h9000, 0, 0, 1, 0, 48'hD000_0000, 48'hFFF, "R12 unused codes no effect"); tick();

    // R7 full cache flush on new fill (DEPTH 4)
    fill(16'd4, 48'h1000, 0, 48'h4100_0000, 48'hFFF, 1, 1); tick();
    fill(16'd4, 48'h2000, 0, 48'h4200_0000, 48'hFFF, 1, 1); tick();
    fill(16'd4, 48'h3000, 0, 48'h4300_0000, 48'hFFF, 1, 1); tick();
    look(16'd2, 48'h9000, 0, 0, 1, 0, 48'hD000_0000, 48'hFFF, "R7 full still holds"); tick();
    look(16'd4, 48'h3004, 0, 0, 1, 0, 48'h4300_0004, 48'hFFF, "R7 last slot"); tick();
    fill(16'd5, 48'h5000, 0, 48'h5500_0000, 48'hFFF, 1, 1); tick();
    look(16'd2, 48'h9000, 0, 0, 0, 0, 48'h0, 48'h0, "R7 flushed old"); tick();
    look(16'd4, 48'h1000, 0, 0, 0, 0, 48'h0, 48'h0, "R7 flushed old 2"); tick();
    look(16'd5, 48'h5008, 0, 0, 1, 0, 48'h5500_0008, 48'hFFF, "R7 new installed"); tick();

    // R11 same-cycle invalidate, fill and lookup
    inv(3'd0, 16'd0, 48'h0);
    fill(16'd6, 48'h6000, 0, 48'h6600_0000, 48'hFFF, 1, 1);
    look(16'd5, 48'h5000, 0, 0, 1, 0, 48'h5500_0000, 48'hFFF, "R11 lookup sees old");
    tick();
    look(16'd5, 48'h5000, 0, 0, 0, 0, 48'h0, 48'h0, "R11 flush applied"); tick();
    look(16'd6, 48'h6123, 0, 0, 1, 0, 48'h6600_0123, 48'hFFF, "R11 fill survives"); tick();
    inv(3'd2, 16'd6, 48'h0);
    fill(16'd6, 48'h7000, 0, 48'h7700_0000, 48'hFFF, 1, 1);
    tick();
    look(16'd6, 48'h6000, 0, 0, 0, 0, 48'h0, 48'h0, "R11 asid flush old gone"); tick();
    look(16'd6, 48'h7000, 0, 0, 1, 0, 48'h7700_0000, 48'hFFF, "R11 asid fill kept"); tick();

    // R8 full-flush codes
    inv(3'd1, 16'd0, 48'h0); tick();
    look(16'd6, 48'h7000, 0, 0, 0, 0, 48'h0, 48'h0, "R8 code 1 flush"); tick();
    fill(16'd7, 48'h8000, 0, 48'h8800_0000, 48'hFFF, 1, 1); tick();
    inv(3'd4, 16'd0, 48'h0); tick();
    look(16'd7, 48'h8000, 0, 0, 0, 0, 48'h0, 48'h0, "R8 code 4 flush"); tick();
    fill(16'd7, 48'h8000, 0, 48'h8800_0000, 48'hFFF, 1, 1); tick();
    inv(3'd0, 16'd0, 48'h0); tick();
    look(16'd7, 48'h8000, 0, 0, 0, 0, 48'h0, 48'h0, "R8 code 0 flush"); tick();

    repeat (3) tick();
    // R5 counters
    chk("R5 hitCount", {32'd0, hitCount}, 64'(expHits));
    chk("R5 missCount", {32'd0, missCount}, 64'(expMiss));
    chk("R2 queue drained", 64'(q.size()), 64'd0);
    finish_run();
  end
endmodule